// File: doc/BRIEF.md
# Machine-Check Error Status and Mask Unit

This unit gathers up to 32 system error event lines into one sticky status register and gates them through a per-bit enable mask. Any source that is both recorded and enabled raises a single registered machine-check request toward the processor core. Software reaches the two registers through a small synchronous port. It reads with a read strobe and an address. It clears recorded errors by writing ones to the status register and programs the enables by writing the mask register.

Two reset inputs are provided. The power-on reset wipes both registers. The soft/hard reset leaves every recorded error and every enable in place, so the cause of a crash can still be read after the system restarts. A configuration input decides whether external interrupt line 0 counts as an error source at all.

Bit numbering follows the convention that bit k of a register sits at vector index 31-k, so bit 0 is the most significant bit. Five positions are implemented by default: bit 0 (external line 0), bit 1 (watchdog error), bit 2 (system bus access error), bit 3 (PCI error) and bit 4 (messaging-unit error). Together these form vector mask 32'hF800_0000.

Top module: `mcheck_unit`

## Requirements
- R1: An asserted event on an implemented position sets that status bit at the next clock edge, and the bit stays 1 until software clears it.
- R2: A write to address 0 clears each status bit whose write-data bit is 1. Write-data bits of 0 leave status unchanged, so a write can never set a status bit.
- R3: Only the power-on reset (por_n low) clears status and mask. The soft/hard reset (sys_rst_n low) keeps both registers intact and forces only mc_req and rd_data to 0.
- R4: Unimplemented positions (outside 32'hF800_0000) always read 0 in status and mask, and ignore events and writes.
- R5: mc_req is a registered OR over (status AND mask). It rises one cycle after an enabled status bit is set and falls one cycle after the last enabled set bit is cleared or disabled.
- R6: A write to address 1 loads the mask (implemented bits only). A mask bit of 1 enables its source, a 0 blocks it, and the mask can be read back at any time.
- R7: A source whose mask bit is 0 still sets its status bit but does not raise mc_req.
- R8: Event line at vector index 31 (bit 0, external line 0) sets its status bit only while ext0_mc_sel is 1.
- R9: When an event and a write-1 clear hit the same status bit in the same cycle, the bit ends at 1.
- R10: After power-on reset the mask is all zeros, so every source starts blocked.
- R11: A read with rd_en high returns, on rd_data one cycle later, the register value from before that edge: address 0 status, 1 mask, 2 and 3 zero. rd_data holds its value while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_n | input | 1 | Soft/hard reset, active low, asynchronous; leaves status and mask alone |
| err_evt | input | 32 | Error event lines, bit k at index 31-k |
| ext0_mc_sel | input | 1 | 1 makes external line 0 a machine-check source |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 2 | Register select: 0 status, 1 mask |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| mc_req | output | 1 | Registered machine-check request |

## Verification
On every cycle, the assertions check the following. Status bits never drop without a matching clear and never appear without a qualified event. An event always wins over a clear. Unimplemented positions stay zero. The mask is stable without a write. The request follows the previous cycle's enabled status. External line 0 is gated by its configuration input. Only the bench's scenarios can show the register-port behaviour: the encoding of writes and reads, and the one-cycle read latency. They also show the survival of status and mask across a soft/hard reset, against a reference model compared on every clock.

// File: rtl/mcu_pkg.sv
package mcu_pkg;
  localparam int SRC_W  = 32;
  localparam int ADDR_W = 2;

  typedef logic [SRC_W-1:0]  src_vec_t;
  typedef logic [ADDR_W-1:0] reg_addr_t;

  localparam reg_addr_t ADDR_STAT = 2'd0;
  localparam reg_addr_t ADDR_MASK = 2'd1;

  // keep only implemented positions, drop external line 0 unless selected
  function automatic src_vec_t qualify_events(src_vec_t evt, src_vec_t impl,
                                              int unsigned ext_idx, logic ext_sel);
    src_vec_t q;
    q = evt & impl;
    if (!ext_sel) q[ext_idx] = 1'b0;
    return q;
  endfunction

  // set has priority over write-one-clear
  function automatic src_vec_t status_next(src_vec_t cur, src_vec_t setv, src_vec_t clrv);
    return setv | (cur & ~clrv);
  endfunction

  function automatic logic any_enabled(src_vec_t stat, src_vec_t mask);
    return |(stat & mask);
  endfunction
endpackage

// File: rtl/mcu_evt_qual.sv
module mcu_evt_qual
  import mcu_pkg::*;
#(
  parameter src_vec_t    IMPL     = 32'hF800_0000,
  parameter int unsigned EXT0_IDX = 31
) (
  input  logic     clk,
  input  logic     por_n,
  input  src_vec_t evt_i,
  input  logic     ext0_sel_i,
  output src_vec_t set_o
);
  assign set_o = qualify_events(evt_i, IMPL, EXT0_IDX, ext0_sel_i);

  assert_ext0_gate_R8: assert property (@(posedge clk) disable iff (!por_n)
    !ext0_sel_i |-> !set_o[EXT0_IDX]);
  assert_set_impl_R4: assert property (@(posedge clk) disable iff (!por_n)
    (set_o & ~IMPL) == '0);
endmodule

// File: rtl/mcu_status_reg.sv
module mcu_status_reg
  import mcu_pkg::*;
#(
  parameter src_vec_t IMPL = 32'hF800_0000
) (
  input  logic     clk,
  input  logic     por_n,
  input  src_vec_t set_i,
  input  src_vec_t clr_i,
  output src_vec_t stat_o
);
  src_vec_t stat_q;
  logic     live_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      stat_q <= '0;
      live_q <= 1'b0;
    end else begin
      stat_q <= status_next(stat_q, set_i, clr_i);
      live_q <= 1'b1;
    end
  end

  assign stat_o = stat_q;

  assert_set_sticks_R1: assert property (@(posedge clk) disable iff (!por_n)
    live_q |-> (($past(set_i) & ~stat_q) == '0));
  assert_no_silent_drop_R2: assert property (@(posedge clk) disable iff (!por_n)
    live_q |-> ((stat_q & $past(stat_q & ~clr_i)) == $past(stat_q & ~clr_i)));
  assert_no_self_set_R2: assert property (@(posedge clk) disable iff (!por_n)
    live_q |-> ((stat_q & ~$past(stat_q) & ~$past(set_i)) == '0));
  assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (!por_n)
    live_q |-> (($past(set_i & clr_i) & ~stat_q) == '0));
  assert_stat_unimpl_R4: assert property (@(posedge clk) disable iff (!por_n)
    (stat_q & ~IMPL) == '0);
endmodule

// File: rtl/mcu_mask_reg.sv
module mcu_mask_reg
  import mcu_pkg::*;
#(
  parameter src_vec_t IMPL = 32'hF800_0000
) (
  input  logic     clk,
  input  logic     por_n,
  input  logic     we_i,
  input  src_vec_t wdata_i,
  output src_vec_t mask_o
);
  src_vec_t mask_q;
  logic     live_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mask_q <= '0;
      live_q <= 1'b0;
    end else begin
      if (we_i) mask_q <= wdata_i & IMPL;
      live_q <= 1'b1;
    end
  end

  assign mask_o = mask_q;

  assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!por_n)
    (live_q && !$past(we_i)) |-> $stable(mask_q));
  assert_mask_unimpl_R4: assert property (@(posedge clk) disable iff (!por_n)
    (mask_q & ~IMPL) == '0);
endmodule

// File: rtl/mcu_req_gen.sv
module mcu_req_gen
  import mcu_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t stat_i,
  input  src_vec_t mask_i,
  output logic     req_o
);
  logic req_q;
  logic live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      live_q <= 1'b0;
    end else begin
      req_q  <= any_enabled(stat_i, mask_i);
      live_q <= 1'b1;
    end
  end

  assign req_o = req_q;

  assert_req_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> (req_q == (|($past(stat_i) & $past(mask_i)))));
  assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && ($past(stat_i & mask_i) == '0)) |-> !req_q);
endmodule

// File: rtl/mcheck_unit.sv
module mcheck_unit
  import mcu_pkg::*;
#(
  parameter src_vec_t    IMPL     = 32'hF800_0000,
  parameter int unsigned EXT0_IDX = 31
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        sys_rst_n,
  input  logic [31:0] err_evt,
  input  logic        ext0_mc_sel,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        mc_req
);
  logic     out_rst_n;
  src_vec_t set_vec;
  src_vec_t clr_vec;
  src_vec_t stat_vec;
  src_vec_t mask_vec;
  logic     stat_wr;
  logic     mask_wr;
  src_vec_t rd_mux;
  src_vec_t rd_q;

  assign out_rst_n = por_n & sys_rst_n;
  assign stat_wr   = wr_en && (addr == ADDR_STAT);
  assign mask_wr   = wr_en && (addr == ADDR_MASK);
  assign clr_vec   = stat_wr ? (wr_data & IMPL) : '0;

  mcu_evt_qual #(.IMPL(IMPL), .EXT0_IDX(EXT0_IDX)) u_qual (
    .clk(clk), .por_n(por_n), .evt_i(err_evt), .ext0_sel_i(ext0_mc_sel), .set_o(set_vec)
  );

  mcu_status_reg #(.IMPL(IMPL)) u_stat (
    .clk(clk), .por_n(por_n), .set_i(set_vec), .clr_i(clr_vec), .stat_o(stat_vec)
  );

  mcu_mask_reg #(.IMPL(IMPL)) u_mask (
    .clk(clk), .por_n(por_n), .we_i(mask_wr), .wdata_i(wr_data), .mask_o(mask_vec)
  );

  mcu_req_gen u_req (
    .clk(clk), .rst_n(out_rst_n), .stat_i(stat_vec), .mask_i(mask_vec), .req_o(mc_req)
  );

  always_comb begin
    unique case (addr)
      ADDR_STAT: rd_mux = stat_vec;
      ADDR_MASK: rd_mux = mask_vec;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge out_rst_n) begin
    if (!out_rst_n)  rd_q <= '0;
    else if (rd_en)  rd_q <= rd_mux;
  end

  assign rd_data = rd_q;

  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!out_rst_n)
    (!rd_en) |=> $stable(rd_q));
endmodule

// File: tb/tb_mcheck_unit.sv
module tb_mcheck_unit;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        sys_rst_n = 1'b1;
  logic [31:0] err_evt = '0;
  logic        ext0_mc_sel = 1'b0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        mc_req;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  string phase = "R3";

  // reference model state
  logic [31:0] m_stat, m_mask, m_rd;
  logic        m_req;

  always #2 clk = ~clk;

  mcheck_unit dut (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .err_evt(err_evt),
    .ext0_mc_sel(ext0_mc_sel), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .mc_req(mc_req)
  );

  function automatic bit is_impl(int idx);
    return idx >= 27;  // bits 0..4 of the register, MSB-first numbering
  endfunction

  always @(posedge clk or negedge por_n or negedge sys_rst_n) begin
    logic [31:0] s0, k0;
    if (!por_n) begin
      m_stat = '0; m_mask = '0; m_rd = '0; m_req = 1'b0;
    end else if (!sys_rst_n) begin
      m_rd = '0; m_req = 1'b0;
      if (clk) begin
        s0 = m_stat; k0 = m_mask;
        for (int i = 0; i < 32; i++) begin
          bit ev, cl;
          ev = err_evt[i] && is_impl(i) && (i != 31 || ext0_mc_sel);
          cl = wr_en && addr == 2'd0 && wr_data[i];
          if (ev) m_stat[i] = 1'b1; else if (cl) m_stat[i] = 1'b0;
          if (wr_en && addr == 2'd1) m_mask[i] = wr_data[i] && is_impl(i);
        end
      end
    end else begin
      s0 = m_stat; k0 = m_mask;
      if (rd_en) m_rd = (addr == 2'd0) ? s0 : (addr == 2'd1) ? k0 : 32'd0;
      m_req = 1'b0;
      for (int i = 0; i < 32; i++) if (s0[i] && k0[i]) m_req = 1'b1;
      for (int i = 0; i < 32; i++) begin
        bit ev, cl;
        ev = err_evt[i] && is_impl(i) && (i != 31 || ext0_mc_sel);
        cl = wr_en && addr == 2'd0 && wr_data[i];
        if (ev) m_stat[i] = 1'b1; else if (cl) m_stat[i] = 1'b0;
        if (wr_en && addr == 2'd1) m_mask[i] = wr_data[i] && is_impl(i);
      end
    end
  end

  // compare against the model every cycle, away from the edges
  always @(negedge clk) begin
    if (!finished) begin
      total++;
      if (rd_data !== m_rd || mc_req !== m_req) begin
        bad++;
        $display("FAIL %s model: rd_data=%h mc_req=%b expected rd_data=%h mc_req=%b",
                 phase, rd_data, mc_req, m_rd, m_req);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    rd_en = 1'b1; addr = a; tick();
    rd_en = 1'b0; v = rd_data;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wr_data = d; tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse(input logic [31:0] e);
    err_evt = e; tick(); err_evt = '0;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk); #1;
    chk("R3 reset mc_req", {31'd0, mc_req}, 32'd0);
    por_n = 1'b1; tick();
    rd(2'd0, v); chk("R3 status after por", v, 32'h0);
    rd(2'd1, v); chk("R10 mask after por", v, 32'h0);

    phase = "R1"; pulse(32'h4000_0000);  // watchdog, bit 1
    tick(); rd(2'd0, v); chk("R1 sticky watchdog", v, 32'h4000_0000);
    phase = "R7"; chk("R7 masked no req", {31'd0, mc_req}, 32'd0);

    phase = "R2"; wr(2'd0, 32'h0); wr(2'd0, 32'h0800_0000);
    rd(2'd0, v); chk("R2 zero/other clears keep bit", v, 32'h4000_0000);

    phase = "R4"; pulse(32'h07FF_FFFF); wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v); chk("R4 mask unimpl reads 0", v, 32'hF800_0000);
    rd(2'd0, v); chk("R4 status unimpl ignored", v, 32'h4000_0000);
    phase = "R5"; chk("R5 req with enabled bit", {31'd0, mc_req}, 32'd1);

    wr(2'd0, 32'h4000_0000);
    chk("R5 req one cycle after clear", {31'd0, mc_req}, 32'd1);
    tick(); chk("R5 req dropped", {31'd0, mc_req}, 32'd0);

    phase = "R8"; ext0_mc_sel = 1'b0; pulse(32'h8000_0000); tick();
    rd(2'd0, v); chk("R8 ext0 gated off", v, 32'h0);
    ext0_mc_sel = 1'b1; pulse(32'h8000_0000); tick();
    rd(2'd0, v); chk("R8 ext0 selected", v, 32'h8000_0000);

    phase = "R9"; err_evt = 32'h2000_0000; wr(2'd0, 32'hA000_0000); err_evt = '0;
    rd(2'd0, v); chk("R9 set beats clear", v, 32'h2000_0000);

    phase = "R6"; wr(2'd1, 32'h1000_0000); tick(); tick();
    chk("R6 req blocked by mask", {31'd0, mc_req}, 32'd0);
    pulse(32'h1800_0000); tick();
    chk("R6 enabled pci raises req", {31'd0, mc_req}, 32'd1);

    phase = "R11"; rd(2'd2, v); chk("R11 addr 2 reads 0", v, 32'h0);
    rd(2'd0, v); tick(); tick(); chk("R11 rd_data holds", rd_data, 32'h3800_0000);

    phase = "R3"; sys_rst_n = 1'b0; tick();
    chk("R3 sys reset clears req", {31'd0, mc_req}, 32'd0);
    sys_rst_n = 1'b1; tick(); tick();
    rd(2'd0, v); chk("R3 status survives sys reset", v, 32'h3800_0000);
    rd(2'd1, v); chk("R3 mask survives sys reset", v, 32'h1000_0000);
    chk("R3 req back after sys reset", {31'd0, mc_req}, 32'd1);

    por_n = 1'b0; tick(); por_n = 1'b1; tick();
    rd(2'd0, v); chk("R3 por clears status", v, 32'h0);
    rd(2'd1, v); chk("R10 por clears mask", v, 32'h0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule